// File: doc/BRIEF.md
# Keyed and Lockable Transmitter Control Register Bank

This block is the control register bank of a serial transmitter. It holds a main control register (core hold and flush request), a lock register, and five configuration registers for the clock divider, operating mode, ping generation, interrupt enables and DMA event enable. Software reaches it through a plain synchronous bus: an address, 16-bit write data, a write strobe and combinational read data. A privileged-write enable input models the processor-level protection gate that every write must pass.

Two guards protect the bank. Writes to the main control and lock registers carry an 8-bit key in bits 15:8 of the same write. Setting the lock freezes every configuration register until the next system reset. The lock itself is a two-state machine: **OPEN**, then **SEALED** after an accepted keyed write with bit 0 set (transition *seal*). The only way back is system reset (transition *reset*). A write that fails any check raises a one-cycle reject pulse. The stored fields drive the rest of the transmitter directly.

Address map, in slots of 16 bits: 0 main control, 1 lock, 2 clock control, 3 operation control, 4 ping control, 5 interrupt control, 6 DMA control. All other addresses are unmapped.

Top module: `txctl_regbank`

## Requirements
- R1: A write to slot 0 takes effect only if bits 15:8 of that write equal 0xA5. Any other key drops the whole write.
- R2: Slot 0 holds core hold in bit 0 (output `core_hold`) and flush request in bit 1 (output `flush_req`). Its bits 15:2, including the key byte, read back as zero.
- R3: The lock register (slot 1) needs the same 0xA5 key in bits 15:8. An accepted write with bit 0 set seals the bank. Slot 1 reads the lock state in bit 0 and zero elsewhere.
- R4: Once sealed, writes to slot 1 are rejected. The lock state leaves SEALED only on system reset.
- R5: While sealed, writes to slots 2 to 6 are rejected and change nothing. Keyed writes to slot 0 still take effect.
- R6: With `priv_en` low, a write to any mapped slot is rejected and changes nothing, whatever its key or the lock state.
- R7: After reset every stored field, every output and every read-back slot is zero, and the bank is OPEN.
- R8: Reads of slots 7 to 15 return zero. Writes to them change nothing and raise no reject pulse.
- R9: `wr_reject` is high for exactly the cycle after each write to a mapped slot that fails a key, lock or privilege check, and is low after every other cycle.
- R10: The configuration fields and their writable bits are as follows; all other bits read zero:
  - slot 2 mask 0x03FF: `div_rst` bit 0, `div_en` bit 1, `div_value` bits 9:2.
  - slot 3 mask 0x07FF: `oper_cfg` bits 10:0.
  - slot 4 mask 0x03FF: `ping_cfg` bits 9:0.
  - slot 5 mask 0x0F0F: `irq1_en` bits 3:0, `irq2_en` bits 11:8.
  - slot 6 mask 0x0001: `dma_evt_en` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| bus_addr | input | ADDR_W | Register slot address |
| bus_wdata | input | 16 | Write data, key in bits 15:8 for slots 0 and 1 |
| bus_we | input | 1 | Write strobe |
| priv_en | input | 1 | Privileged-write enable |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| core_hold | output | 1 | Transmitter core held in reset |
| flush_req | output | 1 | Flush pattern request |
| cfg_locked | output | 1 | Bank is SEALED |
| div_value | output | 8 | Clock divider ratio |
| div_en | output | 1 | Clock divider enable |
| div_rst | output | 1 | Clock divider counter reset |
| oper_cfg | output | 11 | Operation control fields |
| ping_cfg | output | 10 | Ping control fields |
| irq1_en | output | 4 | Event enables for interrupt line 1 |
| irq2_en | output | 4 | Event enables for interrupt line 2 |
| dma_evt_en | output | 1 | DMA event enable |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |

## Verification
The seal transition and a configuration write can land on adjacent edges. A sealing write followed in the very next cycle by a configuration write must see the new lock state. The bench drives that pair back to back with no idle cycle between them. It expects the first write to be accepted with no pulse and the second to be rejected with a pulse and no field change. Constrained random writes mixing keys, privilege and rare seal attempts then check the reject pulse, every output and every read-back slot against a bench model after each write.

// File: rtl/txctl_pkg.sv
package txctl_pkg;

    localparam int DATA_W    = 16;
    localparam int KEY_W     = 8;
    localparam int NUM_CFG   = 5;
    localparam int SLOT_MAIN = 0;
    localparam int SLOT_LOCK = 1;
    localparam int SLOT_CFG0 = 2;
    localparam int NUM_SLOTS = SLOT_CFG0 + NUM_CFG;
    localparam int MAIN_W    = 2;

    typedef enum logic {
        ST_OPEN,
        ST_SEALED
    } lock_state_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_MAIN,
        TGT_LOCK,
        TGT_CFG
    } target_t;

    // Writable bits of each configuration slot, index 0 = slot SLOT_CFG0
    function automatic logic [DATA_W-1:0] cfg_mask(input int idx);
        case (idx)
            0:       return 16'h03FF;
            1:       return 16'h07FF;
            2:       return 16'h03FF;
            3:       return 16'h0F0F;
            4:       return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/txctl_lock_fsm.sv
module txctl_lock_fsm
    import txctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic locked
);

    lock_state_t state_q;
    lock_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (seal_req) state_d = ST_SEALED;
            ST_SEALED: state_d = ST_SEALED;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SEALED: locked = 1'b1;
            default:   locked = 1'b0;
        endcase
    end

endmodule

// File: rtl/txctl_wr_gate.sv
module txctl_wr_gate
    import txctl_pkg::*;
#(
    parameter int               ADDR_W = 4,
    parameter logic [KEY_W-1:0] WR_KEY = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               bus_we,
    input  logic               priv_en,
    input  logic               locked,
    output logic               main_wen,
    output logic               lock_wen,
    output logic [NUM_CFG-1:0] cfg_wen,
    output logic               wr_reject
);

    target_t tgt;
    logic    key_ok;
    logic    accept;
    logic    reject;

    assign key_ok = (key_in == WR_KEY);

    always_comb begin
        tgt = TGT_NONE;
        if (bus_addr == ADDR_W'(SLOT_MAIN)) begin
            tgt = TGT_MAIN;
        end else if (bus_addr == ADDR_W'(SLOT_LOCK)) begin
            tgt = TGT_LOCK;
        end else if (bus_addr >= ADDR_W'(SLOT_CFG0) &&
                     bus_addr <  ADDR_W'(NUM_SLOTS)) begin
            tgt = TGT_CFG;
        end
    end

    always_comb begin
        accept = 1'b0;
        reject = 1'b0;
        unique case (tgt)
            TGT_MAIN: begin
                accept = bus_we && priv_en && key_ok;
                reject = bus_we && !accept;
            end
            TGT_LOCK: begin
                accept = bus_we && priv_en && key_ok && !locked;
                reject = bus_we && !accept;
            end
            TGT_CFG: begin
                accept = bus_we && priv_en && !locked;
                reject = bus_we && !accept;
            end
            default: begin
                accept = 1'b0;
                reject = 1'b0;
            end
        endcase
    end

    assign main_wen = accept && (tgt == TGT_MAIN);
    assign lock_wen = accept && (tgt == TGT_LOCK);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_wen
        assign cfg_wen[g] = accept && (tgt == TGT_CFG) &&
                            (bus_addr == ADDR_W'(SLOT_CFG0 + g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= reject;
        end
    end

endmodule

// File: rtl/txctl_regfile.sv
module txctl_regfile
    import txctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic                      main_wen,
    input  logic [NUM_CFG-1:0]        cfg_wen,
    input  logic                      locked,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [MAIN_W-1:0]         main_q,
    output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);

    logic [DATA_W-1:0] cfg_q [NUM_CFG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
        end else if (main_wen) begin
            main_q <= bus_wdata[MAIN_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (cfg_wen[g]) begin
                cfg_q[g] <= bus_wdata & cfg_mask(g);
            end
        end
        assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q[g];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(SLOT_MAIN)) begin
            bus_rdata = {{(DATA_W-MAIN_W){1'b0}}, main_q};
        end else if (bus_addr == ADDR_W'(SLOT_LOCK)) begin
            bus_rdata = {{(DATA_W-1){1'b0}}, locked};
        end else begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (bus_addr == ADDR_W'(SLOT_CFG0 + i)) begin
                    bus_rdata = cfg_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/txctl_regbank.sv
module txctl_regbank
    import txctl_pkg::*;
#(
    parameter int               ADDR_W = 4,
    parameter logic [KEY_W-1:0] WR_KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              priv_en,
    output logic [15:0]       bus_rdata,
    output logic              core_hold,
    output logic              flush_req,
    output logic              cfg_locked,
    output logic [7:0]        div_value,
    output logic              div_en,
    output logic              div_rst,
    output logic [10:0]       oper_cfg,
    output logic [9:0]        ping_cfg,
    output logic [3:0]        irq1_en,
    output logic [3:0]        irq2_en,
    output logic              dma_evt_en,
    output logic              wr_reject
);

    logic                      main_wen;
    logic                      lock_wen;
    logic [NUM_CFG-1:0]        cfg_wen;
    logic [MAIN_W-1:0]         main_q;
    logic [NUM_CFG*DATA_W-1:0] cfg_flat;
    logic                      unused_rsvd;

    txctl_wr_gate #(
        .ADDR_W (ADDR_W),
        .WR_KEY (WR_KEY)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .key_in    (bus_wdata[15:8]),
        .bus_we    (bus_we),
        .priv_en   (priv_en),
        .locked    (cfg_locked),
        .main_wen  (main_wen),
        .lock_wen  (lock_wen),
        .cfg_wen   (cfg_wen),
        .wr_reject (wr_reject)
    );

    txctl_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (lock_wen && bus_wdata[0]),
        .locked   (cfg_locked)
    );

    txctl_regfile #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .main_wen  (main_wen),
        .cfg_wen   (cfg_wen),
        .locked    (cfg_locked),
        .bus_rdata (bus_rdata),
        .main_q    (main_q),
        .cfg_flat  (cfg_flat)
    );

    assign core_hold  = main_q[0];
    assign flush_req  = main_q[1];
    assign div_rst    = cfg_flat[0*DATA_W + 0];
    assign div_en     = cfg_flat[0*DATA_W + 1];
    assign div_value  = cfg_flat[0*DATA_W + 2 +: 8];
    assign oper_cfg   = cfg_flat[1*DATA_W +: 11];
    assign ping_cfg   = cfg_flat[2*DATA_W +: 10];
    assign irq1_en    = cfg_flat[3*DATA_W +: 4];
    assign irq2_en    = cfg_flat[3*DATA_W + 8 +: 4];
    assign dma_evt_en = cfg_flat[4*DATA_W];

    assign unused_rsvd = ^{cfg_flat[0*DATA_W+10 +: 6], cfg_flat[1*DATA_W+11 +: 5],
                           cfg_flat[2*DATA_W+10 +: 6], cfg_flat[3*DATA_W+4 +: 4],
                           cfg_flat[3*DATA_W+12 +: 4], cfg_flat[4*DATA_W+1 +: 15]};

endmodule

// File: rtl/txctl_regbank_chk.sv
module txctl_regbank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_we,
    input logic              priv_en,
    input logic [15:0]       bus_rdata,
    input logic              core_hold,
    input logic              flush_req,
    input logic              cfg_locked,
    input logic [7:0]        div_value,
    input logic              div_en,
    input logic              div_rst,
    input logic [10:0]       oper_cfg,
    input logic [9:0]        ping_cfg,
    input logic [3:0]        irq1_en,
    input logic [3:0]        irq2_en,
    input logic              dma_evt_en,
    input logic              wr_reject
);

    logic [44:0] cfg_bus;
    logic        to_cfg;
    logic        to_main;
    logic        unmapped;

    assign cfg_bus  = {div_value, div_en, div_rst, oper_cfg, ping_cfg,
                       irq1_en, irq2_en, dma_evt_en};
    assign to_main  = (bus_addr == ADDR_W'(0));
    assign to_cfg   = (bus_addr >= ADDR_W'(2)) && (bus_addr < ADDR_W'(7));
    assign unmapped = (bus_addr >= ADDR_W'(7));

    assert_bad_key_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && priv_en && to_main && bus_wdata[15:8] != 8'hA5)
        |=> ($stable({core_hold, flush_req}) && wr_reject));

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    assert_sealed_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locked && bus_we && to_cfg) |=> ($stable(cfg_bus) && wr_reject));

    assert_no_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !priv_en)
        |=> $stable({cfg_bus, core_hold, flush_req, cfg_locked}));

    assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == 16'h0000));

    assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || unmapped) |=> !wr_reject);

endmodule

bind txctl_regbank txctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txctl_regbank_tb.sv
`timescale 1ns/1ps
module txctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        priv_en = 1'b0;
    logic [15:0] bus_rdata;
    logic        core_hold, flush_req, cfg_locked, div_en, div_rst, dma_evt_en, wr_reject;
    logic [7:0]  div_value;
    logic [10:0] oper_cfg;
    logic [9:0]  ping_cfg;
    logic [3:0]  irq1_en, irq2_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // bench model
    logic [1:0]  m_main;
    logic        m_lock;
    logic [15:0] m_cfg [5];

    always #5 clk = ~clk;

    txctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .priv_en(priv_en), .bus_rdata(bus_rdata),
        .core_hold(core_hold), .flush_req(flush_req), .cfg_locked(cfg_locked),
        .div_value(div_value), .div_en(div_en), .div_rst(div_rst),
        .oper_cfg(oper_cfg), .ping_cfg(ping_cfg), .irq1_en(irq1_en),
        .irq2_en(irq2_en), .dma_evt_en(dma_evt_en), .wr_reject(wr_reject)
    );

    function automatic logic [15:0] mask_of(input int slot);
        case (slot)
            2: return 16'h03FF;
            3: return 16'h07FF;
            4: return 16'h03FF;
            5: return 16'h0F0F;
            6: return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_reject(input int a, input logic [15:0] d, input logic p);
        if (a > 6) return 1'b0;
        if (!p) return 1'b1;
        if (a <= 1 && d[15:8] != 8'hA5) return 1'b1;
        if (a >= 1 && m_lock) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [15:0] exp_read(input int a);
        if (a == 0) return {14'b0, m_main};
        if (a == 1) return {15'b0, m_lock};
        if (a >= 2 && a <= 6) return m_cfg[a-2];
        return 16'h0000;
    endfunction

    function automatic logic [47:0] exp_outs();
        return {m_main[0], m_main[1], m_lock, m_cfg[0][9:2], m_cfg[0][1], m_cfg[0][0],
                m_cfg[1][10:0], m_cfg[2][9:0], m_cfg[3][3:0], m_cfg[3][11:8], m_cfg[4][0]};
    endfunction

    task automatic model_reset();
        m_main = '0;
        m_lock = 1'b0;
        for (int i = 0; i < 5; i++) m_cfg[i] = '0;
    endtask

    task automatic model_write(input int a, input logic [15:0] d, input logic p);
        if (!exp_reject(a, d, p)) begin
            if (a == 0) m_main = d[1:0];
            else if (a == 1) m_lock = m_lock | d[0];
            else if (a >= 2 && a <= 6) m_cfg[a-2] = d & mask_of(a);
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Checks outputs and every read slot; called at a negedge with bus_we low
    task automatic check_state(input string req);
        chk(req, "outputs",
            {core_hold, flush_req, cfg_locked, div_value, div_en, div_rst,
             oper_cfg, ping_cfg, irq1_en, irq2_en, dma_evt_en}, exp_outs());
        for (int a = 0; a < 16; a++) begin
            bus_addr = 4'(a);
            #1;
            chk(req, $sformatf("readback slot %0d", a), 48'(bus_rdata), 48'(exp_read(a)));
        end
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic p, input string req);
        logic er;
        er = exp_reject(a, d, p);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; priv_en = p; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; priv_en = 1'b0;
        model_write(a, d, p);
        chk(req, "wr_reject", 48'(wr_reject), 48'(er));
        check_state(req);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        apply_reset();

        // R7: reset state
        chk("R7", "wr_reject", 48'(wr_reject), 48'd0);
        check_state("R7");

        // R1 / R2: keyed main writes, reserved bits read zero
        do_write(0, 16'hA503, 1'b1, "R1");
        do_write(0, 16'h5A00, 1'b1, "R1_badkey");
        do_write(0, 16'hA5FE, 1'b1, "R2");
        do_write(0, 16'hA5FF, 1'b1, "R2");

        // R6: no privilege
        do_write(0, 16'hA500, 1'b0, "R6");
        do_write(3, 16'hFFFF, 1'b0, "R6");

        // R10: field masks
        for (int s = 2; s <= 6; s++) do_write(s, 16'hFFFF, 1'b1, "R10");
        do_write(5, 16'h0A05, 1'b1, "R10");

        // R8: unmapped slots
        do_write(9, 16'hFFFF, 1'b1, "R8");
        do_write(15, 16'hA501, 1'b1, "R8");

        // R3: lock needs key
        do_write(1, 16'h0001, 1'b1, "R3");
        do_write(1, 16'hA500, 1'b1, "R3");

        // R5 / R9: seal then configuration write in the very next cycle
        @(negedge clk);
        bus_addr = 4'd1; bus_wdata = 16'hA501; priv_en = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        model_write(1, 16'hA501, 1'b1);
        chk("R9", "seal no pulse", 48'(wr_reject), 48'd0);
        chk("R3", "sealed", 48'(cfg_locked), 48'd1);
        bus_addr = 4'd2; bus_wdata = 16'h0000;
        @(negedge clk);
        bus_we = 1'b0; priv_en = 1'b0;
        chk("R5", "b2b reject", 48'(wr_reject), 48'(exp_reject(2, 16'h0000, 1'b1)));
        model_write(2, 16'h0000, 1'b1);
        @(negedge clk);
        chk("R9", "pulse one cycle", 48'(wr_reject), 48'd0);
        check_state("R5");

        // R4: sealed lock ignores writes, R5: main still writable
        do_write(1, 16'hA500, 1'b1, "R4");
        do_write(0, 16'hA500, 1'b1, "R5");
        do_write(6, 16'h0000, 1'b1, "R5");

        // R4 / R7: reset unseals
        apply_reset();
        check_state("R4_reset");

        // random phase, every write checked against the model
        for (int it = 0; it < 1500; it++) begin
            int a;
            logic [15:0] d;
            logic p;
            a = int'($urandom_range(0, 9));
            d = 16'($urandom);
            if (a <= 1 && $urandom_range(0, 3) != 0) d[15:8] = 8'hA5;
            if (a == 1 && $urandom_range(0, 39) != 0) d[0] = 1'b0;
            p = ($urandom_range(0, 9) != 0);
            do_write(a, d, p, "R9_rand");
            if (it == 750) begin
                apply_reset();
                check_state("R7_rand");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule